// File: doc/BRIEF.md
# Two-Write, Three-Read Register File

This block is a small register file for a datapath that must issue two writes and three reads in one clock cycle, every cycle. It is built only from plain memory arrays that each have a single write port and a single read port. Each write port owns its own group of arrays. Within a group there is one array copy per read port, and every copy in the group takes that port's write address and data. The two groups therefore each hold a full image of the register contents, but each image is only correct for the locations its own port wrote last.

A small live-value table, with one selector entry per register, records which write port last updated each location. Each read looks up that table in the same cycle as the array reads. The registered selector then drives a select mux after the two array copies that serve that read port. Reads are synchronous with one cycle of latency. A read of a location that is being written in the same cycle returns the old contents. When both write ports hit the same location in one cycle, write port 1 takes priority.

All ports are plain synchronous pins. There is no handshake and no back-pressure: every port accepts a request on every rising edge, and read data is always produced on the edge after the address.

Top module: `mw_regfile`

## Requirements
- R1: Read data for the address sampled on rising edge t shows on that read port after edge t and holds until edge t+1.
- R2: A write on write port 0 in cycle t is returned by any read port that reads the same address in cycle t+1 or later, as long as no newer write to that address comes between.
- R3: A write on write port 1 in cycle t is returned in the same way as in R2.
- R4: Two writes to different addresses in the same cycle are both stored, and both are readable in later cycles.
- R5: When both write ports are enabled for the same address in one cycle, later reads of that address return write port 1's data.
- R6: A read of an address that is written in the same cycle returns the value held before that write (read-before-write).
- R7: The three read ports take independent addresses, and all three return correct data in the same cycle, including when they share an address.
- R8: Reset makes every location's latest-writer entry point to write port 0. After reset, a location that has not been written since reset reads back the last data written to it through write port 0.
- R9: The latest writer is tracked per location. A write on port 0 after an earlier write on port 1 to the same address makes reads return port 0's data.
- R10: A write port whose enable is low changes neither the stored data nor the latest-writer entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the latest-writer table |
| wr_en | input | NWR (2) | Per-port write enable, bit 1 is write port 1 |
| wr_addr | input | NWR x AW (2x5) | Per-port write address |
| wr_data | input | NWR x DW (2x32) | Per-port write data |
| rd_addr | input | NRD x AW (3x5) | Per-port read address |
| rd_data | output | NRD x DW (3x32) | Per-port read data, one cycle after the address |

## Verification
The assertions assume that both write enables stay low while reset is high. The arrays themselves have no reset, so a write during reset would land in an array without updating the selector table. The assertions also compare data only for locations written since the last reset, because array contents are undefined until written. The bench keeps the enables low around each reset and checks reads only where its model holds a defined value. It also forces address collisions often: between the two writes, and between reads and writes.

// File: rtl/mwrf_pkg.sv
package mwrf_pkg;
  // Width of a selector that names one of n write ports, never below one bit.
  function automatic int sel_width(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rf_bank_ram.sv
module rf_bank_ram #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  // One write, one synchronous read; nonblocking read sees pre-write contents.
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/rf_live_table.sv
module rf_live_table #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH),
  parameter int NWR   = 2,
  parameter int NRD   = 3,
  parameter int SW    = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NWR-1:0]           wr_en,
  input  logic [NWR-1:0][AW-1:0]   wr_addr,
  input  logic [NRD-1:0][AW-1:0]   rd_addr,
  output logic [NRD-1:0][SW-1:0]   rd_sel
);
  logic [SW-1:0] owner [DEPTH];

  // Higher-numbered write port is applied last, so it wins a collision.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) owner[i] <= '0;
      rd_sel <= '0;
    end else begin
      for (int w = 0; w < NWR; w++)
        if (wr_en[w]) owner[wr_addr[w]] <= SW'(w);
      for (int r = 0; r < NRD; r++)
        rd_sel[r] <= owner[rd_addr[r]];
    end
  end
endmodule

// File: rtl/rf_read_sel.sv
module rf_read_sel #(
  parameter int DW  = 32,
  parameter int NWR = 2,
  parameter int SW  = 1
) (
  input  logic [NWR-1:0][DW-1:0] cand,
  input  logic [SW-1:0]          sel,
  output logic [DW-1:0]          dout
);
  // Compare the selector against each port number; port 0 is the fallback.
  always_comb begin
    dout = cand[0];
    for (int w = 1; w < NWR; w++)
      if (sel == SW'(w)) dout = cand[w];
  end
endmodule

// File: rtl/mw_regfile.sv
module mw_regfile #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int NRD  = 3,
  parameter int NWR  = 2,
  parameter int AW   = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NWR-1:0]         wr_en,
  input  logic [NWR-1:0][AW-1:0] wr_addr,
  input  logic [NWR-1:0][DW-1:0] wr_data,
  input  logic [NRD-1:0][AW-1:0] rd_addr,
  output logic [NRD-1:0][DW-1:0] rd_data
);
  localparam int SW = mwrf_pkg::sel_width(NWR);

  // bank_q[r][w]: copy serving read port r inside write group w
  logic [NRD-1:0][NWR-1:0][DW-1:0] bank_q;
  logic [NRD-1:0][SW-1:0]          sel_q;

  for (genvar w = 0; w < NWR; w++) begin : g_grp
    for (genvar r = 0; r < NRD; r++) begin : g_copy
      rf_bank_ram #(.DEPTH(NREG), .DW(DW), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (wr_en[w]),
        .waddr (wr_addr[w]),
        .wdata (wr_data[w]),
        .raddr (rd_addr[r]),
        .rdata (bank_q[r][w])
      );
    end
  end

  rf_live_table #(.DEPTH(NREG), .AW(AW), .NWR(NWR), .NRD(NRD), .SW(SW)) u_lvt (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .rd_sel  (sel_q)
  );

  for (genvar r = 0; r < NRD; r++) begin : g_rmux
    rf_read_sel #(.DW(DW), .NWR(NWR), .SW(SW)) u_mux (
      .cand (bank_q[r]),
      .sel  (sel_q[r]),
      .dout (rd_data[r])
    );
  end
endmodule

// File: rtl/mw_regfile_chk.sv
module mw_regfile_chk #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int NRD  = 3,
  parameter int NWR  = 2,
  parameter int AW   = $clog2(NREG)
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NWR-1:0]         wr_en,
  input logic [NWR-1:0][AW-1:0] wr_addr,
  input logic [NWR-1:0][DW-1:0] wr_data,
  input logic [NRD-1:0][AW-1:0] rd_addr,
  input logic [NRD-1:0][DW-1:0] rd_data
);
  // Locations written since the last reset hold defined data.
  logic [NREG-1:0] seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else
      for (int w = 0; w < NWR; w++)
        if (wr_en[w]) seen[wr_addr[w]] <= 1'b1;
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rp
    // R1: a read of a defined location yields known data one edge later
    assert_known_R1: assert property (@(posedge clk) disable iff (rst)
      seen[rd_addr[r]] |=> !$isunknown(rd_data[r]));

    // R5 and R3: port 1 write is returned by the read issued next cycle
    assert_port1_wins_R5: assert property (@(posedge clk) disable iff (rst)
      ($past(wr_en[1]) && rd_addr[r] == $past(wr_addr[1]))
      |=> rd_data[r] == $past(wr_data[1], 2));

    // R2: port 0 write is returned next cycle unless port 1 hit the same address
    assert_port0_write_R2: assert property (@(posedge clk) disable iff (rst)
      ($past(wr_en[0]) && rd_addr[r] == $past(wr_addr[0]) &&
       !($past(wr_en[1]) && $past(wr_addr[1]) == $past(wr_addr[0])))
      |=> rd_data[r] == $past(wr_data[0], 2));

    // R6: repeating an address with no write in between keeps the data
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (seen[rd_addr[r]] && rd_addr[r] == $past(rd_addr[r]) &&
       !($past(wr_en[0]) && $past(wr_addr[0]) == rd_addr[r]) &&
       !($past(wr_en[1]) && $past(wr_addr[1]) == rd_addr[r]))
      |=> rd_data[r] == $past(rd_data[r]));
  end
endmodule

bind mw_regfile mw_regfile_chk #(
  .NREG(NREG), .DW(DW), .NRD(NRD), .NWR(NWR), .AW(AW)
) u_chk (.*);

// File: tb/sim_mw_regfile.sv
`timescale 1ns/1ps
module sim_mw_regfile;
  localparam int NREG = 32;
  localparam int DW   = 32;
  localparam int AW   = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]         wr_en = '0;
  logic [1:0][AW-1:0] wr_addr = '0;
  logic [1:0][DW-1:0] wr_data = '0;
  logic [2:0][AW-1:0] rd_addr = '0;
  logic [2:0][DW-1:0] rd_data;

  always #10 clk = ~clk;  // 50 MHz

  mw_regfile u0 (.*);

  // Behavioural model: one image per write port plus latest-writer entry.
  logic [DW-1:0] m0 [NREG];
  logic [DW-1:0] m1 [NREG];
  bit            d0 [NREG];
  bit            d1 [NREG];
  bit            own[NREG];

  int vecs = 0;
  int bad  = 0;
  bit done = 1'b0;

  function automatic logic [DW-1:0] expect_rd(input int a);
    return own[a] ? m1[a] : m0[a];
  endfunction

  function automatic bit defined_rd(input int a);
    return own[a] ? d1[a] : d0[a];
  endfunction

  // One cycle: drive at negedge, predict reads from pre-write state,
  // apply writes (port 1 last), check after the next rising edge.
  task automatic cyc(input bit e0, input int a0, input logic [DW-1:0] v0,
                     input bit e1, input int a1, input logic [DW-1:0] v1,
                     input int ra, input int rb, input int rc, input string tag);
    int ras[3];
    logic [DW-1:0] ex[3];
    bit ok[3];
    ras[0] = ra; ras[1] = rb; ras[2] = rc;
    wr_en   = {e1, e0};
    wr_addr[0] = AW'(a0); wr_addr[1] = AW'(a1);
    wr_data[0] = v0;      wr_data[1] = v1;
    for (int r = 0; r < 3; r++) begin
      rd_addr[r] = AW'(ras[r]);
      ex[r] = expect_rd(ras[r]);
      ok[r] = defined_rd(ras[r]);
    end
    if (e0) begin m0[a0] = v0; d0[a0] = 1'b1; own[a0] = 1'b0; end
    if (e1) begin m1[a1] = v1; d1[a1] = 1'b1; own[a1] = 1'b1; end
    @(posedge clk);
    @(negedge clk);
    for (int r = 0; r < 3; r++) begin
      if (ok[r]) begin
        vecs++;
        if (rd_data[r] !== ex[r]) begin
          bad++;
          $display("FAIL %s port%0d addr%0d: got %h expected %h",
                   tag, r, ras[r], rd_data[r], ex[r]);
        end
      end
    end
  endtask

  task automatic do_reset();
    wr_en = '0;
    rst = 1'b1;
    for (int i = 0; i < NREG; i++) own[i] = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NREG; i++) begin
      d0[i] = 1'b0; d1[i] = 1'b0; own[i] = 1'b0;
      m0[i] = '0;   m1[i] = '0;
    end
    @(negedge clk);
    do_reset();

    // R4: two writes to different addresses in one cycle
    cyc(1, 3, 32'hA0A0_0003, 1, 7, 32'hB1B1_0007, 0, 0, 0, "R4");
    // R2, R3, R7: all three ports read, two sharing an address
    cyc(0, 0, 0, 0, 0, 0, 3, 7, 3, "R7");
    // R5: both ports write address 9
    cyc(1, 9, 32'hC0C0_0009, 1, 9, 32'hD1D1_0009, 0, 0, 0, "R5");
    cyc(0, 0, 0, 0, 0, 0, 9, 9, 9, "R5");
    // R6: read and write the same address in one cycle returns old value
    cyc(1, 3, 32'hE0E0_0003, 0, 0, 0, 3, 9, 3, "R6");
    cyc(0, 0, 0, 1, 3, 32'hF1F1_0003, 3, 3, 7, "R6");
    cyc(0, 0, 0, 0, 0, 0, 3, 3, 3, "R3");
    // R9: port 0 overwrites a location last written by port 1
    cyc(1, 7, 32'h1234_0007, 0, 0, 0, 7, 1, 2, "R9");
    cyc(0, 0, 0, 0, 0, 0, 7, 7, 9, "R9");
    // R10: disabled write ports leave data and selection unchanged
    cyc(0, 7, 32'hDEAD_0007, 0, 7, 32'hBEEF_0007, 7, 3, 9, "R10");
    cyc(0, 0, 0, 0, 0, 0, 7, 3, 9, "R10");
    // R8: port 0 then port 1 write address 12; after reset port 0 data shows
    cyc(1, 12, 32'h5555_000C, 0, 0, 0, 12, 12, 12, "R2");
    cyc(0, 0, 0, 1, 12, 32'h6666_000C, 12, 12, 12, "R6");
    cyc(0, 0, 0, 0, 0, 0, 12, 12, 12, "R3");
    do_reset();
    cyc(0, 0, 0, 0, 0, 0, 12, 9, 7, "R8");

    // Fill every location through port 0 so all reads are defined.
    for (int i = 0; i < NREG; i++)
      cyc(1, i, $urandom(), 0, 0, 0, i, (i + 31) % NREG, 0, "R2");

    // R1: random dual writes and triple reads, with forced collisions
    for (int n = 0; n < 4000; n++) begin
      int a0 = $urandom_range(0, NREG - 1);
      int a1 = ($urandom_range(0, 3) == 0) ? a0 : $urandom_range(0, NREG - 1);
      int ra = ($urandom_range(0, 2) == 0) ? a0 : $urandom_range(0, NREG - 1);
      int rb = ($urandom_range(0, 2) == 0) ? a1 : $urandom_range(0, NREG - 1);
      int rc = $urandom_range(0, NREG - 1);
      cyc(1'($urandom_range(0, 1)), a0, $urandom(),
          1'($urandom_range(0, 1)), a1, $urandom(), ra, rb, rc, "R1");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule